// File: doc/BRIEF.md
# Burst-Coalescing Write Buffer

This block sits between a write-through data cache and a memory request port. It queues word writes, each carrying an address, a data word and byte enables. It hands them to memory strictly in arrival order. While it drains, it marks where each burst packet ends. A packet is a run of queued writes whose word addresses rise by one word at a time and stay inside one 4 KB page. The packet ends at the first entry that breaks the run, at a page boundary, or when the queue holds no further entry behind the head.

Both data sides use valid/ready handshakes. On the input side, a write is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the buffer is full, and the cache must hold `in_valid` and its payload until the write is taken. On the output side, a word leaves on any edge where `out_valid` and `out_ready` are both high, and only then is its entry freed. While `out_valid` is high and `out_ready` is low, the head address, data and byte enables hold steady. `out_last` may fall during such a stall if a write that continues the run joins behind the head. It never rises during a stall. The memory side therefore uses the `out_last` value seen on the accepting edge. `full` and `empty` are plain status pins. The cache uses `empty` to hold an uncached read back until every earlier write has left.

Top module: `wr_coalesce_buf`

## Requirements
- R1: After reset, and after a reset applied while entries are queued, `empty`=1, `full`=0, `in_ready`=1 and `out_valid`=0.
- R2: Words leave in the exact order they were accepted, with data and byte enables unchanged. `out_addr` equals the accepted address with bits [1:0] forced to zero. No entry is reordered.
- R3: Once DEPTH writes are queued, `full`=1 and `in_ready`=0. A write offered while full is not stored, so draining yields exactly DEPTH words.
- R4: Within a run where each queued word address is the previous one plus 4 bytes in the same page, `out_last`=0 on every word except the final one.
- R5: When the entry behind the head has an address other than the head address plus 4, including a lower address, `out_last`=1 on the head.
- R6: A head whose byte address has bits [11:2] all ones (last word of a 4 KB page) has `out_last`=1, even when the next entry is the next word address.
- R7: When the head is the only queued entry, `out_last`=1.
- R8: While `out_valid`=1 and `out_ready`=0, `out_addr`, `out_data` and `out_be` stay stable. `out_last` does not rise, and it falls if a contiguous write joins behind a lone head.
- R9: An entry is freed only on an edge with `out_valid` and `out_ready` both high. A stalled head stays at the output and `empty` stays 0.
- R10: `empty`=1 exactly when no write is queued, and it rises on the edge that accepts the last queued word.
- R11: Two queued writes to the same address are not merged. Both leave, each with `out_last`=1.
- R12: The default depth is 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Cache offers a write |
| in_ready | output | 1 | Buffer can take a write (not full) |
| in_addr | input | AW | Byte address of the word; bits [1:0] ignored |
| in_data | input | DW | Write data |
| in_be | input | DW/8 | Byte enables |
| full | output | 1 | All DEPTH entries occupied |
| empty | output | 1 | No write pending |
| out_valid | output | 1 | Head word offered to memory |
| out_ready | input | 1 | Memory accepts the head word |
| out_addr | output | AW | Head word byte address |
| out_data | output | DW | Head word data |
| out_be | output | DW/8 | Head word byte enables |
| out_last | output | 1 | Head word ends its burst packet |

## Verification
The grouping logic is driven with queued batches that contain a rising run followed by a forward gap, a backward step, a run that straddles a 4 KB page edge, a repeated address and a lone write. This separates the break on an ordinary gap from the break on a page edge and from the break on an empty tail. A full-depth contiguous batch with an extra write offered while full shows that back-pressure drops nothing and stores nothing extra. A stalled lone head that is then joined by a contiguous write shows the payload holding while `out_last` falls.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  // Relation between the head entry and the entry queued behind it
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,  // nothing behind the head
    LK_RUN  = 2'd1,  // next word, same page: burst continues
    LK_PAGE = 2'd2,  // next word but across a page edge
    LK_GAP  = 2'd3   // any other address
  } link_e;

  localparam int unsigned BYTE_SHIFT = 2;  // 32-bit words
endpackage

// File: rtl/wcb_store.sv
module wcb_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WA    = 30,
  parameter int unsigned DW    = 32,
  parameter int unsigned BW    = DW / 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [WA-1:0] in_wa,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic [WA-1:0] head_wa,
  output logic [DW-1:0] head_data,
  output logic [BW-1:0] head_be,
  output logic [WA-1:0] next_wa,
  output logic          have_next,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_TOP  = PW'(DEPTH - 1);

  logic [WA-1:0] wa_mem [DEPTH];
  logic [DW-1:0] dt_mem [DEPTH];
  logic [BW-1:0] be_mem [DEPTH];

  logic [PW-1:0] wr_ptr, rd_ptr, rd_nxt;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PTR_TOP) ? '0 : p + 1'b1;
  endfunction

  assign rd_nxt = bump(rd_ptr);

  always_ff @(posedge clk) begin
    if (push) begin
      wa_mem[wr_ptr] <= in_wa;
      dt_mem[wr_ptr] <= in_data;
      be_mem[wr_ptr] <= in_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_wa   = wa_mem[rd_ptr];
  assign head_data = dt_mem[rd_ptr];
  assign head_be   = be_mem[rd_ptr];
  assign next_wa   = wa_mem[rd_nxt];
  assign have_next = (count > CW'(1));
  assign full      = (count == CNT_FULL);
  assign empty     = (count == '0);

  // R3: the neighbour never pushes into a full store
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_FULL));
  // R9: a word is removed only when one is present
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  // R10: occupancy moves by exactly one on a lone push or pop
  p_count_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
  p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/wcb_link.sv
module wcb_link
  import wcb_pkg::*;
#(
  parameter int unsigned WA        = 30,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned OFFW     = PAGE_BITS - BYTE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          have_next,
  input  logic [WA-1:0] head_wa,
  input  logic [WA-1:0] next_wa,
  output link_e         kind
);
  logic step_ok, page_end;

  assign step_ok  = (next_wa == head_wa + 1'b1);
  assign page_end = &head_wa[OFFW-1:0];

  always_comb begin
    if (!have_next)    kind = LK_NONE;
    else if (!step_ok) kind = LK_GAP;
    else if (page_end) kind = LK_PAGE;
    else               kind = LK_RUN;
  end

  // R6: the final word of a page never continues a burst
  p_page_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_end |-> (kind != LK_RUN));
  // R7: a burst cannot continue into an absent entry
  p_tail_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !have_next |-> (kind == LK_NONE));
endmodule

// File: rtl/wr_coalesce_buf.sv
module wr_coalesce_buf
  import wcb_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned BW       = DW / 8,
  localparam int unsigned WA       = AW - BYTE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic          full,
  output logic          empty,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic [BW-1:0] out_be,
  output logic          out_last
);
  logic          push, pop, have_next;
  logic [WA-1:0] head_wa, next_wa;
  link_e         kind;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  wcb_store #(.DEPTH(DEPTH), .WA(WA), .DW(DW), .BW(BW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .in_wa     (in_addr[AW-1:BYTE_SHIFT]),
    .in_data   (in_data),
    .in_be     (in_be),
    .head_wa   (head_wa),
    .head_data (out_data),
    .head_be   (out_be),
    .next_wa   (next_wa),
    .have_next (have_next),
    .full      (full),
    .empty     (empty)
  );

  wcb_link #(.WA(WA), .PAGE_BITS(PAGE_BITS)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_next (have_next),
    .head_wa   (head_wa),
    .next_wa   (next_wa),
    .kind      (kind)
  );

  assign out_addr = {head_wa, {BYTE_SHIFT{1'b0}}};
  assign out_last = (kind != LK_RUN);

  // R8: stalled head payload holds
  p_hold_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_data) && $stable(out_be)));
  // R8: end marker of a stalled head never rises
  p_last_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !$rose(out_last));
  // R6: last word of a page always closes its packet (port view)
  p_page_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_addr[PAGE_BITS-1:BYTE_SHIFT])) |-> out_last);
  // R3: back-pressure only with something queued
  p_full_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !empty);
endmodule

// File: tb/wr_coalesce_buf_test.sv
`timescale 1ns/1ps
module wr_coalesce_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be = '0;
  logic        full, empty, out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr, out_data;
  logic [3:0]  out_be;
  logic        out_last;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wr_coalesce_buf uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be), .full(full),
    .empty(empty), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .out_be(out_be),
    .out_last(out_last)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    logic        last;  // expected end marker
    logic        endb;  // drain after this entry
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // batch 1: run of four, forward gap, backward step, tail
    '{32'h0000_0100, 32'hA000_0001, 4'hF, 1'b0, 1'b0},  // R4
    '{32'h0000_0104, 32'hA000_0002, 4'h3, 1'b0, 1'b0},  // R4
    '{32'h0000_0108, 32'hA000_0003, 4'hC, 1'b0, 1'b0},  // R4
    '{32'h0000_010C, 32'hA000_0004, 4'hF, 1'b1, 1'b0},  // R5 gap
    '{32'h0000_0200, 32'hA000_0005, 4'h1, 1'b1, 1'b0},  // R5 backward
    '{32'h0000_01FC, 32'hA000_0006, 4'h8, 1'b1, 1'b1},  // R7 tail
    // batch 2: page edge, repeated address
    '{32'h0000_0FF8, 32'hB000_0001, 4'hF, 1'b0, 1'b0},  // R4
    '{32'h0000_0FFC, 32'hB000_0002, 4'hF, 1'b1, 1'b0},  // R6
    '{32'h0000_1000, 32'hB000_0003, 4'h6, 1'b0, 1'b0},  // R4 new page
    '{32'h0000_1004, 32'hB000_0004, 4'hF, 1'b1, 1'b0},  // R11
    '{32'h0000_1004, 32'hB000_0005, 4'h9, 1'b1, 1'b1},  // R11 R7
    // batch 3: lone write
    '{32'h0000_3000, 32'hC000_0001, 4'hF, 1'b1, 1'b1}   // R7
  };

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d; in_be = be;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic beat(input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic last, input string tag);
    #1;
    chk(out_valid === 1'b1, {tag, " R2 out_valid"}, 32'(out_valid), 32'd1);
    chk(out_addr === a, {tag, " R2 out_addr"}, out_addr, a);
    chk(out_data === d, {tag, " R2 out_data"}, out_data, d);
    chk(out_be === be, {tag, " R2 out_be"}, 32'(out_be), 32'(be));
    chk(out_last === last, {tag, " out_last"}, 32'(out_last), 32'(last));
    @(negedge clk);
  endtask

  initial begin
    int start;
    start = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(empty === 1'b1, "R1 empty after reset", 32'(empty), 32'd1);
    chk(full === 1'b0, "R1 full after reset", 32'(full), 32'd0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: queue each batch with memory stalled, then drain it
    for (int k = 0; k < NV; k++) begin
      push(VEC[k].a, VEC[k].d, VEC[k].be);
      if (VEC[k].endb) begin
        out_ready = 1'b1;
        for (int i = start; i <= k; i++)
          beat(VEC[i].a, VEC[i].d, VEC[i].be, VEC[i].last, "R4/R5/R6/R7/R11");
        out_ready = 1'b0;
        #1;
        chk(empty === 1'b1, "R10 empty after drain", 32'(empty), 32'd1);
        chk(out_valid === 1'b0, "R10 no word after drain", 32'(out_valid), 32'd0);
        start = k + 1;
      end
    end

    // R8/R9: stalled lone head, then a contiguous write joins it
    push(32'h0000_5000, 32'hD000_0001, 4'hF);
    #1;
    chk(out_last === 1'b1, "R7 lone head last", 32'(out_last), 32'd1);
    push(32'h0000_5004, 32'hD000_0002, 4'hF);
    #1;
    chk(out_addr === 32'h0000_5000, "R9 stalled head kept", out_addr, 32'h0000_5000);
    chk(out_data === 32'hD000_0001, "R8 stalled data stable", out_data, 32'hD000_0001);
    chk(out_last === 1'b0, "R8 last falls on join", 32'(out_last), 32'd0);
    chk(empty === 1'b0, "R9 not freed while stalled", 32'(empty), 32'd0);
    out_ready = 1'b1;
    beat(32'h0000_5000, 32'hD000_0001, 4'hF, 1'b0, "R8");
    beat(32'h0000_5004, 32'hD000_0002, 4'hF, 1'b1, "R8");
    out_ready = 1'b0;
    #1;
    chk(empty === 1'b1, "R10 empty after pair", 32'(empty), 32'd1);

    // R3/R12: fill the default depth of 8, offer one more, drain
    for (int i = 0; i < 8; i++)
      push(32'h0000_0400 + 32'(4 * i), 32'hE000_0000 + 32'(i), 4'hF);
    #1;
    chk(full === 1'b1, "R12 full after 8 writes", 32'(full), 32'd1);
    chk(in_ready === 1'b0, "R3 in_ready low when full", 32'(in_ready), 32'd0);
    push(32'h000D_EAD0, 32'hDEAD_BEEF, 4'hF);
    #1;
    chk(full === 1'b1, "R3 still full", 32'(full), 32'd1);
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++)
      beat(32'h0000_0400 + 32'(4 * i), 32'hE000_0000 + 32'(i), 4'hF,
           (i == 7), "R3 R4");
    out_ready = 1'b0;
    #1;
    chk(empty === 1'b1, "R3 extra write not stored", 32'(empty), 32'd1);
    chk(out_valid === 1'b0, "R3 nothing beyond depth", 32'(out_valid), 32'd0);

    // R1: reset while entries are queued
    push(32'h0000_6000, 32'h1, 4'hF);
    push(32'h0000_6004, 32'h2, 4'hF);
    rst_n = 1'b0;
    #1;
    chk(empty === 1'b1, "R1 empty after mid reset", 32'(empty), 32'd1);
    chk(out_valid === 1'b0, "R1 out_valid after mid reset", 32'(out_valid), 32'd0);
    chk(in_ready === 1'b1, "R1 in_ready after mid reset", 32'(in_ready), 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule